// File: doc/BRIEF.md
# Interrupt Cause Collector with Level and Message Signalling

This block keeps a 32-bit register of pending interrupt causes. Bits are set by hardware event sources inside the chip, and software can also set them to inject an interrupt. Software clears causes through a second write register that acts as a bit-clear mask. The collected causes drive one of two signalling styles. In level mode a held interrupt line is raised. In message mode a one-cycle pulse is issued for every raise event.

Software reaches the block through a simple register port with a write strobe, a read strobe, a byte address, write data and combinational read data. Three addresses are decoded. The status address returns the cause register. The raise address ORs the written word into the causes. The lower address clears every cause bit that is set in the written word. Each hardware source has a one-bit request input, and each request is mapped by parameter to a fixed cause bit. By default source 0 is mapped to bit 0 (computation done) and source 1 to bit 8 (transfer done). A mode input selects message signalling when high.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset the cause register reads 0, `irq_level` is 0 and `msg_pulse` is 0.
- R2: A read with `reg_rd` high at address 0x24 returns the cause register on `reg_rdata` in the same cycle. Any other read address returns 0.
- R3: A write to address 0x60 ORs `reg_wdata` into the cause register at the next clock edge. Bits that are already set stay set.
- R4: A write to address 0x64 clears, at the next clock edge, every cause bit whose `reg_wdata` bit is 1. All other bits keep their value.
- R5: A high `src_req[i]` sets the cause bit chosen for source i at the next edge. The default mapping is source 0 to bit 0 and source 1 to bit 8.
- R6: In level mode (`msg_mode` = 0), a raise event that leaves the cause register nonzero sets `irq_level` at the next edge, and `msg_pulse` stays 0. A raise event is a write to 0x60 or any high `src_req` bit.
- R7: In message mode (`msg_mode` = 1), each cycle that has a raise event and leaves the cause register nonzero produces `msg_pulse` high for exactly the next cycle. This includes raising a bit that is already set and writing 0 to 0x60 while causes are pending. `irq_level` does not change.
- R8: A write to 0x64 deasserts `irq_level` only if the cause register becomes 0 and `msg_mode` is 0. A partial clear, or a clear made in message mode, leaves `irq_level` high.
- R9: When a hardware request and a write to 0x64 hit the same bit in the same cycle, the clear is applied first and the set second, so the bit ends up set and `irq_level` stays high in level mode.
- R10: Writes to addresses other than 0x60 and 0x64 do not change the cause register.
- R11: A raise that leaves the cause register at 0 (a write of 0 to 0x60 with no causes pending) produces no pulse and does not raise `irq_level`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| src_req | input | 2 | Per-source cause set requests |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| irq_level | output | 1 | Level-sensitive interrupt line |
| msg_pulse | output | 1 | One-cycle message interrupt pulse |

## Verification
A hardware set request and a software clear can land in the same clock cycle. The bench provokes this by holding `src_req[0]` high during the cycle of a write to 0x64 whose mask covers bit 0 and also bit 8, which is pending. The result passes if bit 0 survives, bit 8 is cleared and the level line stays high. A second overlap is a mode change while causes are pending. The bench clears the causes in message mode, then clears again in level mode, and checks that the line falls only on the second clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Decoded kind of a register port access
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_RAISE = 2'd1,
      ACC_LOWER = 2'd2,
      ACC_OTHER = 2'd3
   } acc_kind_e;

   // Per-cycle summary handed from the cause store to the signalling stage
   typedef struct packed {
      logic raise_evt;   // some source or software raised this cycle
      logic lower_evt;   // software issued a clear this cycle
      logic next_nz;     // cause register will be nonzero after the edge
      logic fresh;       // at least one bit goes from 0 to 1
   } notify_evt_t;

   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_ADDR_W = 8;

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
   import irq_agg_pkg::*;
#(
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned STAT_OFS  = 'h24,
   parameter int unsigned RAISE_OFS = 'h60,
   parameter int unsigned LOWER_OFS = 'h64
) (
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] cause_q,
   output logic              sw_raise_en,
   output logic              sw_lower_en,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(RAISE_OFS);
   localparam logic [ADDR_W-1:0] A_LOWER = ADDR_W'(LOWER_OFS);

   // Elaboration-time sanity checks on the address map
   if (STAT_OFS >= (1 << ADDR_W) || RAISE_OFS >= (1 << ADDR_W) || LOWER_OFS >= (1 << ADDR_W)) begin : g_bad_range
      $error("irq_agg_decode: an offset does not fit in ADDR_W bits");
   end
   if (RAISE_OFS == LOWER_OFS || RAISE_OFS == STAT_OFS || LOWER_OFS == STAT_OFS) begin : g_bad_alias
      $error("irq_agg_decode: register offsets must be distinct");
   end
   if ((STAT_OFS % 4) != 0 || (RAISE_OFS % 4) != 0 || (LOWER_OFS % 4) != 0) begin : g_bad_align
      $error("irq_agg_decode: offsets must be word aligned");
   end

   acc_kind_e wr_kind;

   always_comb begin
      wr_kind = ACC_NONE;
      if (reg_wr) begin
         if (reg_addr == A_RAISE)      wr_kind = ACC_RAISE;
         else if (reg_addr == A_LOWER) wr_kind = ACC_LOWER;
         else                          wr_kind = ACC_OTHER;
      end
   end

   assign sw_raise_en = (wr_kind == ACC_RAISE);
   assign sw_lower_en = (wr_kind == ACC_LOWER);

   // Read path: only the status address returns data
   assign reg_rdata = (reg_rd && reg_addr == A_STAT) ? cause_q : '0;

endmodule

// File: rtl/irq_agg_cause.sv
module irq_agg_cause
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned SRC_POS [NUM_SRC] = '{0, 8}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               sw_raise_en,
   input  logic               sw_lower_en,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  cause_q,
   output notify_evt_t        evt
);

   if (DATA_W < 1) begin : g_bad_width
      $error("irq_agg_cause: DATA_W must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_nsrc
      $error("irq_agg_cause: NUM_SRC must be at least 1");
   end

   // OR chain that folds every hardware request onto its cause bit
   logic [DATA_W-1:0] hw_part [NUM_SRC+1];
   assign hw_part[0] = '0;

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      if (SRC_POS[gi] >= DATA_W) begin : g_bad_pos
         $error("irq_agg_cause: source bit position outside the cause register");
      end
      localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'(1) << SRC_POS[gi];
      assign hw_part[gi+1] = hw_part[gi] | (src_req[gi] ? SRC_MASK : '0);

      AST_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         src_req[gi] |=> cause_q[SRC_POS[gi]]);   // R5 R9
   end

   logic [DATA_W-1:0] raise_vec;
   logic [DATA_W-1:0] lower_vec;
   logic [DATA_W-1:0] cause_d;

   assign raise_vec = hw_part[NUM_SRC] | (sw_raise_en ? wdata : '0);
   assign lower_vec = sw_lower_en ? wdata : '0;

   // One storage cell per cause bit: clear is applied before set
   for (genvar gb = 0; gb < DATA_W; gb++) begin : g_bit
      assign cause_d[gb] = (cause_q[gb] & ~lower_vec[gb]) | raise_vec[gb];
      always_ff @(posedge clk) begin
         if (!rst_n) cause_q[gb] <= 1'b0;
         else        cause_q[gb] <= cause_d[gb];
      end
   end

   assign evt.raise_evt = sw_raise_en | (|src_req);
   assign evt.lower_evt = sw_lower_en;
   assign evt.next_nz   = |cause_d;
   assign evt.fresh     = |(raise_vec & ~cause_q);

   AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_raise_en |=> ((cause_q & $past(wdata)) == $past(wdata)));   // R3

   AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_lower_en |=> ((cause_q & $past(lower_vec & ~raise_vec)) == '0));   // R4

endmodule

// File: rtl/irq_agg_notify.sv
module irq_agg_notify
   import irq_agg_pkg::*;
#(
   parameter bit PULSE_ON_REPEAT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        msg_mode,
   input  notify_evt_t evt,
   output logic        irq_level,
   output logic        msg_pulse
);

   logic pulse_gate;
   logic level_set;
   logic level_clr;

   // Pulse on every raise, or only on raises that set a new bit
   assign pulse_gate = evt.fresh | PULSE_ON_REPEAT;

   assign level_set = evt.raise_evt & evt.next_nz & ~msg_mode;
   assign level_clr = evt.lower_evt & ~evt.next_nz & ~msg_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_level <= 1'b0;
         msg_pulse <= 1'b0;
      end else begin
         msg_pulse <= evt.raise_evt & evt.next_nz & msg_mode & pulse_gate;
         if (level_set)      irq_level <= 1'b1;
         else if (level_clr) irq_level <= 1'b0;
      end
   end

   AST_PULSE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> $past(msg_mode));   // R7

   AST_PULSE_NEEDS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> $past(evt.raise_evt));   // R7

   AST_LEVEL_FALL_COND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_level) |-> ($past(evt.lower_evt) && !$past(msg_mode)));   // R8

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned NUM_SRC   = 2,
   parameter int unsigned SRC_POS [NUM_SRC] = '{0, 8},
   parameter int unsigned STAT_OFS  = 'h24,
   parameter int unsigned RAISE_OFS = 'h60,
   parameter int unsigned LOWER_OFS = 'h64,
   parameter bit          PULSE_ON_REPEAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               msg_mode,
   output logic               irq_level,
   output logic               msg_pulse
);

   logic              sw_raise_en;
   logic              sw_lower_en;
   logic [DATA_W-1:0] cause_q;
   notify_evt_t       evt;

   irq_agg_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STAT_OFS  (STAT_OFS),
      .RAISE_OFS (RAISE_OFS),
      .LOWER_OFS (LOWER_OFS)
   ) u_decode (
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_addr    (reg_addr),
      .cause_q     (cause_q),
      .sw_raise_en (sw_raise_en),
      .sw_lower_en (sw_lower_en),
      .reg_rdata   (reg_rdata)
   );

   irq_agg_cause #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC),
      .SRC_POS (SRC_POS)
   ) u_cause (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_req     (src_req),
      .sw_raise_en (sw_raise_en),
      .sw_lower_en (sw_lower_en),
      .wdata       (reg_wdata),
      .cause_q     (cause_q),
      .evt         (evt)
   );

   irq_agg_notify #(
      .PULSE_ON_REPEAT (PULSE_ON_REPEAT)
   ) u_notify (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_mode  (msg_mode),
      .evt       (evt),
      .irq_level (irq_level),
      .msg_pulse (msg_pulse)
   );

   AST_PULSE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> (cause_q != '0));   // R7 R11

   AST_LEVEL_RISE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_level) |-> (cause_q != '0));   // R6

   AST_LEVEL_FALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_level) |-> (cause_q == '0));   // R8

   AST_OTHER_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !sw_raise_en && !sw_lower_en && src_req == '0) |=> $stable(cause_q));   // R10

endmodule

// File: tb/sim_irq_cause_agg.sv
module sim_irq_cause_agg;

   localparam logic [7:0] A_STAT  = 8'h24;
   localparam logic [7:0] A_RAISE = 8'h60;
   localparam logic [7:0] A_LOWER = 8'h64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  src_req = '0;
   logic        msg_mode = 1'b0;
   logic        irq_level;
   logic        msg_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_cause_agg u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .src_req   (src_req),
      .msg_mode  (msg_mode),
      .irq_level (irq_level),
      .msg_pulse (msg_pulse)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // One clock cycle with the given stimulus; returns 1 ns after the edge
   task automatic step(bit wr, logic [7:0] addr, logic [31:0] data, logic [1:0] req);
      @(negedge clk);
      reg_wr    = wr;
      reg_addr  = addr;
      reg_wdata = data;
      src_req   = req;
      @(posedge clk);
      #1;
      reg_wr  = 1'b0;
      src_req = '0;
   endtask

   task automatic idle();
      step(1'b0, 8'h00, 32'h0, 2'b00);
   endtask

   task automatic read_at(logic [7:0] addr, output logic [31:0] val);
      reg_rd   = 1'b1;
      reg_addr = addr;
      #1;
      val    = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic check_cause(string tag, logic [31:0] exp);
      logic [31:0] v;
      read_at(A_STAT, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      chk("R1 level after reset", {31'b0, irq_level}, 32'h0);
      chk("R1 pulse after reset", {31'b0, msg_pulse}, 32'h0);
      check_cause("R1 cause after reset", 32'h0);
   endtask

   task automatic t_sw_raise_lower();
      msg_mode = 1'b0;
      step(1'b1, A_RAISE, 32'h0000_0005, 2'b00);
      check_cause("R3 raise 0x5", 32'h5);
      chk("R6 level after raise", {31'b0, irq_level}, 32'h1);
      chk("R6 no pulse in level mode", {31'b0, msg_pulse}, 32'h0);
      step(1'b1, A_RAISE, 32'h0000_0034, 2'b00);
      check_cause("R3 OR-in keeps old bits", 32'h35);
      step(1'b1, A_LOWER, 32'h0000_0014, 2'b00);
      check_cause("R4 partial clear", 32'h21);
      chk("R8 level held on partial clear", {31'b0, irq_level}, 32'h1);
      step(1'b1, A_LOWER, 32'hFFFF_FFFF, 2'b00);
      check_cause("R4 full clear", 32'h0);
      chk("R8 level drops when empty", {31'b0, irq_level}, 32'h0);
   endtask

   task automatic t_hw_sources();
      msg_mode = 1'b0;
      step(1'b0, 8'h00, 32'h0, 2'b10);
      check_cause("R5 source 1 sets bit 8", 32'h100);
      chk("R6 level from hw source", {31'b0, irq_level}, 32'h1);
      step(1'b0, 8'h00, 32'h0, 2'b01);
      check_cause("R5 source 0 sets bit 0", 32'h101);
      step(1'b1, A_LOWER, 32'h0000_0101, 2'b00);
      check_cause("R4 clear hw bits", 32'h0);
      chk("R8 level drops after hw clear", {31'b0, irq_level}, 32'h0);
   endtask

   task automatic t_msg_mode();
      msg_mode = 1'b1;
      step(1'b1, A_RAISE, 32'h0000_0002, 2'b00);
      chk("R7 pulse on raise", {31'b0, msg_pulse}, 32'h1);
      chk("R7 level unchanged in msg mode", {31'b0, irq_level}, 32'h0);
      idle();
      chk("R7 pulse lasts one cycle", {31'b0, msg_pulse}, 32'h0);
      step(1'b1, A_RAISE, 32'h0000_0002, 2'b00);
      chk("R7 pulse on repeat raise", {31'b0, msg_pulse}, 32'h1);
      step(1'b1, A_RAISE, 32'h0000_0000, 2'b00);
      chk("R7 pulse on zero raise with pending cause", {31'b0, msg_pulse}, 32'h1);
      step(1'b0, 8'h00, 32'h0, 2'b01);
      chk("R7 pulse from hw source, cycle 1", {31'b0, msg_pulse}, 32'h1);
      step(1'b0, 8'h00, 32'h0, 2'b01);
      chk("R7 pulse from held hw source, cycle 2", {31'b0, msg_pulse}, 32'h1);
      check_cause("R7 causes in msg mode", 32'h3);
      step(1'b1, A_LOWER, 32'hFFFF_FFFF, 2'b00);
      chk("R7 no pulse on clear", {31'b0, msg_pulse}, 32'h0);
      chk("R7 level still low", {31'b0, irq_level}, 32'h0);
      check_cause("R4 clear in msg mode", 32'h0);
   endtask

   task automatic t_mode_switch();
      msg_mode = 1'b0;
      step(1'b1, A_RAISE, 32'h0000_0008, 2'b00);
      chk("R6 level before switch", {31'b0, irq_level}, 32'h1);
      msg_mode = 1'b1;
      step(1'b1, A_LOWER, 32'h0000_0008, 2'b00);
      check_cause("R4 clear while in msg mode", 32'h0);
      chk("R8 level held when cleared in msg mode", {31'b0, irq_level}, 32'h1);
      msg_mode = 1'b0;
      step(1'b1, A_LOWER, 32'h0000_0000, 2'b00);
      chk("R8 level drops on clear in level mode", {31'b0, irq_level}, 32'h0);
   endtask

   task automatic t_collision();
      msg_mode = 1'b0;
      step(1'b1, A_RAISE, 32'h0000_0101, 2'b00);
      step(1'b1, A_LOWER, 32'h0000_0101, 2'b01);
      check_cause("R9 hw set wins over same-cycle clear", 32'h1);
      chk("R9 level stays high", {31'b0, irq_level}, 32'h1);
      step(1'b1, A_LOWER, 32'h0000_0001, 2'b00);
      check_cause("R9 cleanup", 32'h0);
   endtask

   task automatic t_other_addr();
      logic [31:0] v;
      msg_mode = 1'b0;
      step(1'b1, A_RAISE, 32'h0000_0040, 2'b00);
      step(1'b1, 8'h28, 32'hFFFF_FFFF, 2'b00);
      check_cause("R10 write to 0x28 ignored", 32'h40);
      step(1'b1, A_STAT, 32'hFFFF_FFFF, 2'b00);
      check_cause("R10 write to status ignored", 32'h40);
      read_at(A_RAISE, v);
      chk("R2 read of non-status address", v, 32'h0);
      read_at(8'h20, v);
      chk("R2 read of 0x20", v, 32'h0);
      step(1'b1, A_LOWER, 32'h0000_0040, 2'b00);
      check_cause("R10 cleanup", 32'h0);
   endtask

   task automatic t_zero_raise();
      msg_mode = 1'b1;
      step(1'b1, A_RAISE, 32'h0000_0000, 2'b00);
      chk("R11 no pulse on empty raise", {31'b0, msg_pulse}, 32'h0);
      msg_mode = 1'b0;
      step(1'b1, A_RAISE, 32'h0000_0000, 2'b00);
      chk("R11 no level on empty raise", {31'b0, irq_level}, 32'h0);
      check_cause("R11 cause still empty", 32'h0);
   endtask

   initial begin
      t_reset();
      t_sw_raise_lower();
      t_hw_sources();
      t_msg_mode();
      t_mode_switch();
      t_collision();
      t_other_addr();
      t_zero_raise();
      idle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule